// File: doc/BRIEF.md
# Configurable SPI master/slave engine

This block moves one character at a time over a four-wire serial peripheral interface: serial clock, master-out/slave-in, master-in/slave-out and an active-low slave transmit-enable. It can act as bus master, generating the clock and the enable from a programmable divider. It can also act as slave, taking the clock and the enable from outside through a short synchronizer. Shifting is full duplex: one transfer sends a word and receives a word. Transmission can be switched off while reception goes on.

The parallel side is flat and register-like. A mode word chooses the role, the clock idle level, the phase scheme, the transmit enable, the character length and the rate. A write strobe supplies the transmit word. A read strobe acknowledges the received word. A done flag and an overrun flag report completion. The mode word is sampled only while no transfer is running. Each pin has a separate value, output-enable and input port, so the pad ring can build the tri-state drivers.

Top module: `spi_engine`

## Requirements
- R1: In master mode one bit lasts D clock cycles, where D = cfg_rate + 1 for cfg_rate 3..127 and D = 4 for cfg_rate 0, 1 or 2. In each bit, sclk_o sits at the idle level for the first floor(D/2) cycles and at the active level for the remaining cycles.
- R2: The character length is cfg_len_m1 + 1 bits (1 to 16). A master write starts a transfer: ste_n_o is low from the cycle after the accepted tx_wr for exactly L*D cycles, and it carries exactly L clock pulses.
- R3: Bits travel most-significant first. The transmit word is taken from tx_data[15] downward, so it is left-justified. The received word appears in rx_data[L-1:0] with the upper bits zero, so it is right-justified.
- R4: The clock idle level equals cfg_cpol (0 idles low, 1 idles high). The active level is its inverse.
- R5: With cfg_cpha = 0, new data goes out on the idle-to-active clock edge and is captured on the active-to-idle edge. With cfg_cpha = 1, the first bit is on the data line before the first clock edge, data is captured on idle-to-active edges and new data goes out on active-to-idle edges.
- R6: With cfg_tx_en = 0 the data output-enable (mosi_oe in master mode, miso_oe in slave mode) stays low, and the received word is still captured. The two data output-enables are never high together.
- R7: One cycle after the final active-to-idle edge of a character, rx_done goes high and rx_data holds the received word. A pulse on rx_rd clears rx_done.
- R8: If a character completes while rx_done is still high and rx_rd is not pulsed, rx_ovr goes high and rx_data takes the newer word. The rx_rd pulse clears rx_ovr.
- R9: In slave mode, clock edges are ignored while ste_n_i is high, and the bit count restarts. A character cut short by ste_n_i going high sets no flag and does not corrupt the next one.
- R10: Changes on the cfg inputs, and further tx_wr pulses, have no effect on a transfer in progress.
- R11: After reset, ste_n_o = 1, sclk_o = 0, busy = 0, rx_done = 0, rx_ovr = 0 and both data output-enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_master | input | 1 | 1 selects master role, 0 slave |
| cfg_cpol | input | 1 | Clock idle level |
| cfg_cpha | input | 1 | 1 selects the early-data (phase delayed) scheme |
| cfg_tx_en | input | 1 | Enables the serial data output |
| cfg_len_m1 | input | 4 | Character length minus one |
| cfg_rate | input | 7 | Bit-rate divider value |
| tx_wr | input | 1 | Transmit word write strobe |
| tx_data | input | 16 | Transmit word, left-justified |
| rx_rd | input | 1 | Receive word read strobe |
| rx_data | output | 16 | Last received word, right-justified |
| rx_done | output | 1 | Character complete flag |
| rx_ovr | output | 1 | Overrun flag |
| busy | output | 1 | Transfer in progress |
| sclk_o | output | 1 | Serial clock value |
| sclk_oe | output | 1 | Serial clock output-enable (master) |
| sclk_i | input | 1 | Serial clock from pad (slave) |
| ste_n_o | output | 1 | Transmit-enable value (master) |
| ste_n_i | input | 1 | Transmit-enable from pad (slave) |
| mosi_o | output | 1 | Master-out data value |
| mosi_oe | output | 1 | Master-out output-enable |
| mosi_i | input | 1 | Master-out data from pad (slave) |
| miso_o | output | 1 | Slave-out data value |
| miso_oe | output | 1 | Slave-out output-enable |
| miso_i | input | 1 | Slave-out data from pad (master) |

## Verification
The hardest case to reach from the ports is a slave character that starts, loses its transmit-enable partway through, and is then followed by a clean character. Only a wrong bit count left over from the aborted character would show up, and only in the second received word. The stimulus first toggles the slave clock with the enable high, then sends three bits of an eight-bit character and drops the enable. It then runs a complete character and checks the received word and the slave-out bits. In master mode, the mode word and an extra write are changed partway through a long transfer. A per-cycle waveform model that keeps the original divider then catches any leak.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;

   // One-cycle event strobes from a clock source (divider or synchronizer)
   typedef struct packed {
      logic lead;   // idle -> active clock transition
      logic trail;  // active -> idle clock transition
   } spi_edge_t;

endpackage

// File: rtl/spi_rate_gen.sv
module spi_rate_gen #(
   parameter int RATE_W  = 7,
   parameter int MIN_DIV = 4,
   localparam int CNT_W  = RATE_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic [RATE_W-1:0] rate,
   output spi_eng_pkg::spi_edge_t tick
);
   logic [CNT_W-1:0] div, half, cnt;

   assign div  = (rate < RATE_W'(MIN_DIV - 1)) ? CNT_W'(MIN_DIV) : ({1'b0, rate} + CNT_W'(1));
   assign half = div >> 1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt <= '0;
      else if (!run)           cnt <= '0;
      else if (cnt == div - 1) cnt <= '0;
      else                     cnt <= cnt + CNT_W'(1);
   end

   assign tick.lead  = run && (cnt == half - 1);
   assign tick.trail = run && (cnt == div - 1);

   AST_TICK_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      tick.lead |-> !tick.trail);  // R1

endmodule

// File: rtl/spi_slave_sync.sv
module spi_slave_sync #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cpol,
   input  logic sclk_i,
   input  logic ste_n_i,
   input  logic sdi_i,
   output spi_eng_pkg::spi_edge_t tick,
   output logic ste_s,
   output logic ste_fall,
   output logic sdi_s
);
   logic [SYNC_STAGES-1:0] c_sclk, c_ste, c_sdi;
   logic act_now, act_prev, ste_prev;

   generate
      if (SYNC_STAGES == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               c_sclk <= '0;
               c_ste  <= '1;
               c_sdi  <= '0;
            end else begin
               c_sclk <= sclk_i;
               c_ste  <= ste_n_i;
               c_sdi  <= sdi_i;
            end
         end
      end else begin : g_chain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               c_sclk <= '0;
               c_ste  <= '1;
               c_sdi  <= '0;
            end else begin
               c_sclk <= {c_sclk[SYNC_STAGES-2:0], sclk_i};
               c_ste  <= {c_ste[SYNC_STAGES-2:0],  ste_n_i};
               c_sdi  <= {c_sdi[SYNC_STAGES-2:0],  sdi_i};
            end
         end
      end
   endgenerate

   assign act_now = c_sclk[SYNC_STAGES-1] ^ cpol;
   assign ste_s   = c_ste[SYNC_STAGES-1];
   assign sdi_s   = c_sdi[SYNC_STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_prev <= 1'b0;
         ste_prev <= 1'b1;
      end else begin
         act_prev <= act_now;
         ste_prev <= ste_s;
      end
   end

   assign tick.lead  = !ste_s &&  act_now && !act_prev;
   assign tick.trail = !ste_s && !act_now &&  act_prev;
   assign ste_fall   = ste_prev && !ste_s;

endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core #(
   parameter int DATA_W = 16,
   localparam int LEN_W = $clog2(DATA_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              clr,
   input  spi_eng_pkg::spi_edge_t tick,
   input  logic              cpha,
   input  logic [LEN_W-1:0]  len_m1,
   input  logic              sin,
   input  logic [DATA_W-1:0] tx_word,
   output logic              sout,
   output logic              char_done,
   output logic [DATA_W-1:0] rx_word
);
   logic [DATA_W-1:0] tx_sr, rx_sr;
   logic [LEN_W-1:0]  bitcnt;
   logic              do_sample, do_launch;

   assign do_sample = cpha ? tick.lead  : tick.trail;
   assign do_launch = cpha ? tick.trail : (tick.lead && bitcnt != '0);
   assign char_done = tick.trail && (bitcnt == len_m1) && !clr;
   assign sout      = tx_sr[DATA_W-1];
   // with late capture the final bit is captured on the completing edge
   assign rx_word   = cpha ? rx_sr : {rx_sr[DATA_W-2:0], sin};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_sr  <= '0;
         rx_sr  <= '0;
         bitcnt <= '0;
      end else if (load) begin
         tx_sr  <= tx_word;
         rx_sr  <= '0;
         bitcnt <= '0;
      end else if (clr) begin
         rx_sr  <= '0;
         bitcnt <= '0;
      end else begin
         if (do_sample) rx_sr <= {rx_sr[DATA_W-2:0], sin};
         if (do_launch) tx_sr <= {tx_sr[DATA_W-2:0], 1'b0};
         if (tick.trail) bitcnt <= char_done ? '0 : bitcnt + LEN_W'(1);
      end
   end

   AST_BITCNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      bitcnt <= len_m1 || clr || load || bitcnt == '0);  // R2

endmodule

// File: rtl/spi_engine.sv
module spi_engine
   import spi_eng_pkg::*;
#(
   parameter int DATA_W      = 16,
   parameter int RATE_W      = 7,
   parameter int MIN_DIV     = 4,
   parameter int SYNC_STAGES = 2,
   localparam int LEN_W      = $clog2(DATA_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_master,
   input  logic              cfg_cpol,
   input  logic              cfg_cpha,
   input  logic              cfg_tx_en,
   input  logic [LEN_W-1:0]  cfg_len_m1,
   input  logic [RATE_W-1:0] cfg_rate,
   input  logic              tx_wr,
   input  logic [DATA_W-1:0] tx_data,
   input  logic              rx_rd,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_done,
   output logic              rx_ovr,
   output logic              busy,
   output logic              sclk_o,
   output logic              sclk_oe,
   input  logic              sclk_i,
   output logic              ste_n_o,
   input  logic              ste_n_i,
   output logic              mosi_o,
   output logic              mosi_oe,
   input  logic              mosi_i,
   output logic              miso_o,
   output logic              miso_oe,
   input  logic              miso_i
);
   initial begin
      assert (DATA_W >= 2 && DATA_W <= 32) else $error("DATA_W out of range");
      assert (MIN_DIV >= 2 && MIN_DIV <= (1 << RATE_W)) else $error("MIN_DIV out of range");
      assert (SYNC_STAGES >= 1) else $error("SYNC_STAGES must be at least 1");
   end

   logic              act_master, act_cpol, act_cpha, act_tx_en;
   logic [LEN_W-1:0]  act_len;
   logic [RATE_W-1:0] act_rate;
   logic              m_busy, sclk_act, start, busy_i;
   spi_edge_t         rg_tick, sl_tick, sel_tick;
   logic              sl_ste, sl_fall, sl_sdi;
   logic              sout, char_done, load, clr, sin;
   logic [DATA_W-1:0] rx_word, tx_hold, tx_word;

   assign busy_i = m_busy | (~act_master & ~sl_ste);
   assign start  = tx_wr & ~busy_i & cfg_master;

   // mode word is sampled only between transfers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_master <= 1'b0;
         act_cpol   <= 1'b0;
         act_cpha   <= 1'b0;
         act_tx_en  <= 1'b0;
         act_len    <= '0;
         act_rate   <= '0;
      end else if (!busy_i) begin
         act_master <= cfg_master;
         act_cpol   <= cfg_cpol;
         act_cpha   <= cfg_cpha;
         act_tx_en  <= cfg_tx_en;
         act_len    <= cfg_len_m1;
         act_rate   <= cfg_rate;
      end
   end

   spi_rate_gen #(.RATE_W(RATE_W), .MIN_DIV(MIN_DIV)) u_rate (
      .clk(clk), .rst_n(rst_n), .run(m_busy), .rate(act_rate), .tick(rg_tick));

   spi_slave_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .cpol(act_cpol), .sclk_i(sclk_i), .ste_n_i(ste_n_i),
      .sdi_i(mosi_i), .tick(sl_tick), .ste_s(sl_ste), .ste_fall(sl_fall), .sdi_s(sl_sdi));

   assign sel_tick = act_master ? rg_tick : sl_tick;
   assign sin      = act_master ? miso_i : sl_sdi;
   assign load     = start | (~act_master & (sl_fall | (char_done & ~sl_ste)));
   assign clr      = ~act_master & sl_ste;
   assign tx_word  = start ? tx_data : tx_hold;

   spi_shift_core #(.DATA_W(DATA_W)) u_core (
      .clk(clk), .rst_n(rst_n), .load(load), .clr(clr), .tick(sel_tick),
      .cpha(act_cpha), .len_m1(act_len), .sin(sin), .tx_word(tx_word),
      .sout(sout), .char_done(char_done), .rx_word(rx_word));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_busy   <= 1'b0;
         sclk_act <= 1'b0;
         tx_hold  <= '0;
      end else begin
         if (tx_wr) tx_hold <= tx_data;
         if (start)                          m_busy <= 1'b1;
         else if (char_done && act_master)   m_busy <= 1'b0;
         if (start)                          sclk_act <= 1'b0;
         else if (act_master && rg_tick.lead) sclk_act <= 1'b1;
         else if (rg_tick.trail)             sclk_act <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_data <= '0;
         rx_done <= 1'b0;
         rx_ovr  <= 1'b0;
      end else begin
         if (char_done) rx_data <= rx_word;
         rx_done <= char_done | (rx_done & ~rx_rd);
         if (char_done && rx_done && !rx_rd) rx_ovr <= 1'b1;
         else if (rx_rd)                     rx_ovr <= 1'b0;
      end
   end

   assign busy    = busy_i;
   assign sclk_o  = sclk_act ^ act_cpol;
   assign sclk_oe = act_master;
   assign ste_n_o = ~m_busy;
   assign mosi_o  = sout;
   assign miso_o  = sout;
   assign mosi_oe = m_busy & act_tx_en;
   assign miso_oe = ~act_master & ~sl_ste & act_tx_en;

   AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      (act_master && ste_n_o) |-> (sclk_o == act_cpol));  // R4
   AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> !ste_n_o);  // R2
   AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable({act_rate, act_len, act_cpha, act_cpol, act_master}));  // R10
   AST_DONE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_rd && !char_done) |=> !rx_done);  // R7
   AST_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_done && char_done && !rx_rd) |=> rx_ovr);  // R8
   AST_OE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({mosi_oe, miso_oe}));  // R6
   AST_SLAVE_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      (!act_master && sl_ste) |-> !char_done);  // R9

endmodule

// File: tb/sim_spi_engine.sv
`timescale 1ns/100ps
module sim_spi_engine;
   logic        clk = 1'b0, rst_n = 1'b0;
   logic        cfg_master = 1'b0, cfg_cpol = 1'b0, cfg_cpha = 1'b0, cfg_tx_en = 1'b1;
   logic [3:0]  cfg_len_m1 = 4'd7;
   logic [6:0]  cfg_rate = 7'd0;
   logic        tx_wr = 1'b0, rx_rd = 1'b0;
   logic [15:0] tx_data = '0;
   logic [15:0] rx_data;
   logic        rx_done, rx_ovr, busy, sclk_o, sclk_oe, ste_n_o, mosi_o, mosi_oe, miso_o, miso_oe;
   logic        sclk_i = 1'b0, ste_n_i = 1'b1, mosi_i = 1'b0, miso_i = 1'b0;
   int          n_chk = 0, n_bad = 0;

   always #2.5 clk = ~clk;

   spi_engine u0 (
      .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .cfg_cpol(cfg_cpol),
      .cfg_cpha(cfg_cpha), .cfg_tx_en(cfg_tx_en), .cfg_len_m1(cfg_len_m1), .cfg_rate(cfg_rate),
      .tx_wr(tx_wr), .tx_data(tx_data), .rx_rd(rx_rd), .rx_data(rx_data), .rx_done(rx_done),
      .rx_ovr(rx_ovr), .busy(busy), .sclk_o(sclk_o), .sclk_oe(sclk_oe), .sclk_i(sclk_i),
      .ste_n_o(ste_n_o), .ste_n_i(ste_n_i), .mosi_o(mosi_o), .mosi_oe(mosi_oe), .mosi_i(mosi_i),
      .miso_o(miso_o), .miso_oe(miso_oe), .miso_i(miso_i));

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic int lmask(input int len);
      return (len >= 16) ? 32'hffff : ((1 << len) - 1);
   endfunction

   task automatic rd_ack();
      @(negedge clk); rx_rd = 1'b1;
      @(negedge clk); rx_rd = 1'b0;
   endtask

   // Master transfer against a behavioural per-cycle waveform model and a slave model
   task automatic master_xfer(input int rate, input int len, input bit pol, input bit pha,
                              input bit txen, input logic [15:0] txw, input logic [15:0] sw,
                              input bit disturb);
      int d, half, total, wave_err, oe_err, sidx, leads;
      logic prev, exp_s, exp_cs;
      logic [15:0] got;
      d = (rate < 3) ? 4 : rate + 1;
      half = d / 2; total = len * d;
      wave_err = 0; oe_err = 0; sidx = 0; leads = 0; got = '0;
      @(negedge clk);
      cfg_master = 1'b1; cfg_cpol = pol; cfg_cpha = pha; cfg_tx_en = txen;
      cfg_rate = 7'(rate); cfg_len_m1 = 4'(len - 1); tx_data = txw; tx_wr = 1'b1;
      miso_i = sw[len-1];
      prev = pol;
      for (int k = 0; k <= total; k++) begin
         @(negedge clk);
         if (k == 0) tx_wr = 1'b0;
         exp_s  = ((k < total) && ((k % d) >= half)) ^ pol;
         exp_cs = (k >= total);
         if (sclk_o !== exp_s || ste_n_o !== exp_cs) begin
            if (wave_err == 0)
               $display("  cycle %0d: sclk=%b exp %b, ste_n=%b exp %b", k, sclk_o, exp_s, ste_n_o, exp_cs);
            wave_err++;
         end
         if (k < total && mosi_oe !== txen) oe_err++;
         if (sclk_o !== prev) begin
            if (sclk_o !== pol) begin
               if (pha) got = {got[14:0], mosi_o};
               else if (leads > 0) sidx++;
               leads++;
            end else begin
               if (!pha) got = {got[14:0], mosi_o};
               else sidx++;
            end
            prev = sclk_o;
            if (sidx < len) miso_i = sw[len-1-sidx];
         end
         if (disturb && k == 5) begin
            cfg_rate = 7'(rate ^ 21); cfg_len_m1 = 4'(15 - (len - 1)); cfg_cpha = ~pha;
            tx_data = ~txw; tx_wr = 1'b1;
         end
         if (disturb && k == 6) tx_wr = 1'b0;
      end
      chk(wave_err == 0, disturb ? "R10 waveform kept during config change" : "R1 sclk/ste waveform", wave_err, 0);
      chk(leads == len, "R2 clock pulse count", leads, len);
      chk(sclk_o == pol, "R4 idle level after transfer", int'(sclk_o), int'(pol));
      chk(rx_done == 1'b1, "R7 done after last edge", int'(rx_done), 1);
      chk(rx_data == 16'(int'(sw) & lmask(len)), "R3 received word right-justified", int'(rx_data), int'(sw) & lmask(len));
      if (txen)
         chk((int'(got) & lmask(len)) == (int'(txw) >> (16 - len)), "R5 transmitted bits msb first",
             int'(got) & lmask(len), int'(txw) >> (16 - len));
      chk(oe_err == 0, "R6 data output enable", oe_err, 0);
      cfg_rate = 7'(rate); cfg_len_m1 = 4'(len - 1); cfg_cpha = pha;
   endtask

   // Slave transfer: the bench plays master on the pads with 5-cycle quarter periods
   task automatic slave_xfer(input int len, input int nbits, input bit pol, input bit pha,
                             input bit txen, input logic [15:0] hold, input logic [15:0] mw);
      logic [15:0] got;
      int oe_err;
      got = '0; oe_err = 0;
      @(negedge clk);
      cfg_master = 1'b0; cfg_cpol = pol; cfg_cpha = pha; cfg_tx_en = txen;
      cfg_len_m1 = 4'(len - 1); sclk_i = pol; tx_data = hold; tx_wr = 1'b1;
      @(negedge clk); tx_wr = 1'b0;
      repeat (4) @(negedge clk);
      ste_n_i = 1'b0;
      repeat (6) @(negedge clk);
      for (int b = 0; b < nbits; b++) begin
         repeat (5) @(negedge clk); mosi_i = mw[len-1-b];
         repeat (5) @(negedge clk); sclk_i = ~pol;
         repeat (5) @(negedge clk); got = {got[14:0], miso_o};
         if (miso_oe !== txen || mosi_oe !== 1'b0) oe_err++;
         repeat (5) @(negedge clk); sclk_i = pol;
      end
      repeat (6) @(negedge clk);
      if (nbits == len) begin
         chk(rx_done == 1'b1, "R7 slave done", int'(rx_done), 1);
         chk(rx_data == 16'(int'(mw) & lmask(len)), "R9 slave received word", int'(rx_data), int'(mw) & lmask(len));
         if (txen)
            chk((int'(got) & lmask(len)) == (int'(hold) >> (16 - len)), "R5 slave transmitted bits",
                int'(got) & lmask(len), int'(hold) >> (16 - len));
         chk(oe_err == 0, "R6 slave output enables", oe_err, 0);
      end else begin
         chk(rx_done == 1'b0, "R9 cut-short character sets no flag", int'(rx_done), 0);
      end
      ste_n_i = 1'b1;
      repeat (6) @(negedge clk);
   endtask

   task automatic report();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      report();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state
      chk(ste_n_o == 1'b1 && sclk_o == 1'b0 && busy == 1'b0, "R11 reset pins",
          {ste_n_o, sclk_o, busy}, 3'b100);
      chk(rx_done == 1'b0 && rx_ovr == 1'b0 && mosi_oe == 1'b0 && miso_oe == 1'b0, "R11 reset flags",
          {rx_done, rx_ovr, mosi_oe, miso_oe}, 0);

      master_xfer(0, 8, 1'b0, 1'b0, 1'b1, 16'hA500, 16'h003C, 1'b0);
      rd_ack();
      chk(rx_done == 1'b0, "R7 read clears done", int'(rx_done), 0);
      master_xfer(2, 16, 1'b1, 1'b1, 1'b1, 16'hC3A9, 16'h5E71, 1'b0);  rd_ack();
      master_xfer(3, 5, 1'b0, 1'b1, 1'b1, 16'hB800, 16'h0015, 1'b0);   rd_ack();
      master_xfer(4, 8, 1'b1, 1'b0, 1'b1, 16'h6900, 16'h00D2, 1'b0);   rd_ack();
      master_xfer(127, 1, 1'b0, 1'b0, 1'b1, 16'h8000, 16'h0001, 1'b0); rd_ack();
      master_xfer(7, 12, 1'b0, 1'b1, 1'b0, 16'hFFF0, 16'h0A5C, 1'b0);  rd_ack();
      master_xfer(5, 10, 1'b1, 1'b0, 1'b1, 16'h9D40, 16'h02B7, 1'b1);  rd_ack();

      // R8 overrun: two characters without a read
      master_xfer(3, 4, 1'b0, 1'b0, 1'b1, 16'h5000, 16'h0009, 1'b0);
      chk(rx_ovr == 1'b0, "R8 no overrun after first", int'(rx_ovr), 0);
      master_xfer(3, 4, 1'b0, 1'b0, 1'b1, 16'hA000, 16'h0006, 1'b0);
      chk(rx_ovr == 1'b1, "R8 overrun set", int'(rx_ovr), 1);
      rd_ack();
      chk(rx_done == 1'b0 && rx_ovr == 1'b0, "R8 read clears overrun", {rx_done, rx_ovr}, 0);

      slave_xfer(8, 8, 1'b0, 1'b0, 1'b1, 16'h9600, 16'h005B); rd_ack();
      slave_xfer(16, 16, 1'b1, 1'b1, 1'b1, 16'h3CE5, 16'hA17E); rd_ack();
      slave_xfer(6, 6, 1'b0, 1'b1, 1'b0, 16'hFC00, 16'h002D); rd_ack();

      // R9 edges with enable high are ignored
      cfg_master = 1'b0; cfg_cpol = 1'b0; cfg_cpha = 1'b0; cfg_len_m1 = 4'd0;
      for (int t = 0; t < 8; t++) begin
         repeat (4) @(negedge clk); sclk_i = ~sclk_i; mosi_i = ~mosi_i;
      end
      sclk_i = 1'b0;
      repeat (6) @(negedge clk);
      chk(rx_done == 1'b0, "R9 edges ignored while enable high", int'(rx_done), 0);
      slave_xfer(8, 3, 1'b0, 1'b0, 1'b1, 16'hF000, 16'h00E1);
      slave_xfer(8, 8, 1'b0, 1'b0, 1'b1, 16'h4B00, 16'h0087); rd_ack();

      report();
      $finish;
   end
endmodule